// File: doc/BRIEF.md
# Memory-Mapped 64-bit Compare Timer

This block is a machine timer for one processor core, reached over a simple 32-bit register bus. It holds a 64-bit tick counter. While the timer runs, the counter advances by a programmable step each time a 12-bit prescale divider wraps. Software loads a 64-bit compare value. When the counter reaches that value, the block raises a raw machine-timer interrupt line. A separate peripheral interrupt line is raised only through a sticky status bit, which an enable bit gates.

Software can clear the status bit by writing a one to it. A test register lets software set the status bit on purpose, but only while the interrupt is enabled. The counter words can be read but cannot be written. The alert test register accepts writes and does nothing with them.

Top module: `mtimer_core`

## Requirements
- R1: After reset the registers read as follows: run control 0, config 0x00010000 (step 1, prescale 0), both compare words 0xFFFFFFFF, enable 0, status 0 and counter 0. Both interrupt outputs are low.
- R2: Read data appears on `rsp_rdata` in the cycle after a read request. Byte offsets: run control 0x004 (bit 0 = run), config 0x100 (prescale in [11:0], step in [23:16]), compare low 0x10C, compare high 0x110, enable 0x114 (bit 0). Each of these reads back the last value written to its defined fields.
- R3: While run is set, the counter advances by step once every prescale+1 clock edges. After K running edges from reset it holds floor(K/(prescale+1))*step. While run is clear, the counter holds its value.
- R4: Offsets 0x104 and 0x108 read the counter's low and high words. Writes to these offsets have no effect.
- R5: `irq_mtimer` is high exactly when run is set and the 64-bit unsigned compare value is less than or equal to the counter. The enable bit has no effect on it. A compare write is reflected from the cycle after the write.
- R6: When the compare condition holds and enable bit 0 is set, status bit 0 (offset 0x118) is set. `irq_periph` equals status bit 0 AND enable bit 0.
- R7: A write to status with bit 0 at 1 clears status bit 0. A write with bit 0 at 0 leaves it unchanged.
- R8: A write to the interrupt test register (offset 0x11C) with bit 0 at 1 sets status bit 0 only when enable bit 0 is set. Otherwise the write has no effect.
- R9: Reads return 0 from the alert test register (offset 0x000), from the interrupt test register and from unmapped offsets in the 0x400-byte window. Writes to the alert test register change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus request valid |
| req_write | input | 1 | Request is a write |
| req_addr | input | 10 | Byte address inside the window |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, one cycle after the request |
| irq_mtimer | output | 1 | Raw machine-timer interrupt |
| irq_periph | output | 1 | Enable-gated peripheral interrupt |

## Verification
The hardest situation to reach from the ports is a running timer whose counter sits at a known value long enough to sweep the compare value across it. The counter can only be loaded by letting it count.

The stimulus runs the counter for an exact number of edges with prescale 0, then stops it. Next it sets the prescale to its maximum and restarts the timer, so the counter stays frozen for 4096 edges while run is set. The compare value is then stepped below, onto and above the frozen count. Separate sweeps of prescale and step check the counting arithmetic from reset.

// File: rtl/mtmr_pkg.sv
// Shared constants for the compare timer: register byte offsets of the
// bus window. Assumes a 10-bit byte address and 32-bit word access.
package mtmr_pkg;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_ALERT    = 10'h000;
    localparam logic [ADDR_W-1:0] OFS_RUN      = 10'h004;
    localparam logic [ADDR_W-1:0] OFS_CFG      = 10'h100;
    localparam logic [ADDR_W-1:0] OFS_CNT_LO   = 10'h104;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI   = 10'h108;
    localparam logic [ADDR_W-1:0] OFS_CMP_LO   = 10'h10C;
    localparam logic [ADDR_W-1:0] OFS_CMP_HI   = 10'h110;
    localparam logic [ADDR_W-1:0] OFS_EN       = 10'h114;
    localparam logic [ADDR_W-1:0] OFS_STATUS   = 10'h118;
    localparam logic [ADDR_W-1:0] OFS_TEST     = 10'h11C;
endpackage

// File: rtl/mtmr_regs.sv
// Register file and bus decode. Holds run, config, compare and enable.
// Produces one-cycle strobes for the status clear and the test set.
// Returns read data registered one cycle after a read request.
// Assumes one request per cycle and full-word accesses. Any address
// that is not one of the defined offsets is treated as unmapped.
module mtmr_regs
    import mtmr_pkg::*;
#(
    parameter int PRESCALE_W = 12,
    parameter int STEP_W     = 8,
    parameter int STEP_LSB   = 16,
    localparam int CNT_W     = 2 * DATA_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [CNT_W-1:0]      cnt_val,
    input  logic                  status_bit,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic                  run_bit,
    output logic [PRESCALE_W-1:0] prescale,
    output logic [STEP_W-1:0]     step,
    output logic [CNT_W-1:0]      cmp_val,
    output logic                  en_bit,
    output logic                  clr_strobe,
    output logic                  test_strobe
);
    logic          wr_req;
    logic          rd_req;
    logic [DATA_W-1:0] rd_mux;

    assign wr_req = req_valid && req_write;
    assign rd_req = req_valid && !req_write;

    // Write strobes for the status and test registers.
    assign clr_strobe  = wr_req && (req_addr == OFS_STATUS) && req_wdata[0];
    assign test_strobe = wr_req && (req_addr == OFS_TEST)   && req_wdata[0];

    // Store written fields into the writable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_bit  <= 1'b0;
            prescale <= '0;
            step     <= STEP_W'(1);
            cmp_val  <= '1;
            en_bit   <= 1'b0;
        end else if (wr_req) begin
            unique case (req_addr)
                OFS_RUN:    run_bit  <= req_wdata[0];
                OFS_CFG: begin
                    prescale <= req_wdata[PRESCALE_W-1:0];
                    step     <= req_wdata[STEP_LSB +: STEP_W];
                end
                OFS_CMP_LO: cmp_val[DATA_W-1:0]     <= req_wdata;
                OFS_CMP_HI: cmp_val[CNT_W-1:DATA_W] <= req_wdata;
                OFS_EN:     en_bit   <= req_wdata[0];
                default:    ;
            endcase
        end
    end

    // Select the read value for the addressed register.
    always_comb begin
        rd_mux = '0;
        unique case (req_addr)
            OFS_RUN:    rd_mux[0] = run_bit;
            OFS_CFG: begin
                rd_mux[PRESCALE_W-1:0]      = prescale;
                rd_mux[STEP_LSB +: STEP_W]  = step;
            end
            OFS_CNT_LO: rd_mux = cnt_val[DATA_W-1:0];
            OFS_CNT_HI: rd_mux = cnt_val[CNT_W-1:DATA_W];
            OFS_CMP_LO: rd_mux = cmp_val[DATA_W-1:0];
            OFS_CMP_HI: rd_mux = cmp_val[CNT_W-1:DATA_W];
            OFS_EN:     rd_mux[0] = en_bit;
            OFS_STATUS: rd_mux[0] = status_bit;
            default:    rd_mux = '0;
        endcase
    end

    // Register read data, zero when no read was requested.
    always_ff @(posedge clk) begin
        if (!rst_n) rsp_rdata <= '0;
        else        rsp_rdata <= rd_req ? rd_mux : '0;
    end
endmodule

// File: rtl/mtmr_tick.sv
// Prescale divider and 64-bit tick counter. While run is high, the
// divider counts 0..prescale, and on the wrap edge the counter adds
// step. Both hold while run is low. Assumes the config is stable
// across a wrap (a change is picked up on the next edge).
module mtmr_tick #(
    parameter int PRESCALE_W = 12,
    parameter int STEP_W     = 8,
    parameter int CNT_W      = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run_bit,
    input  logic [PRESCALE_W-1:0] prescale,
    input  logic [STEP_W-1:0]     step,
    output logic [CNT_W-1:0]      cnt_val,
    output logic [PRESCALE_W-1:0] pre_val
);
    logic wrap;

    assign wrap = (pre_val == prescale);

    // Advance the divider and the counter while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_val <= '0;
            cnt_val <= '0;
        end else if (run_bit) begin
            if (wrap) begin
                pre_val <= '0;
                cnt_val <= cnt_val + {{(CNT_W-STEP_W){1'b0}}, step};
            end else begin
                pre_val <= pre_val + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mtmr_irq.sv
// Compare and interrupt logic. The raw line follows run && cmp <= cnt
// and ignores the enable. The sticky status bit is set by a hit or a
// test strobe while enabled, and is cleared by a write-one strobe.
// A set and a clear in the same cycle leave the bit set.
module mtmr_irq #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_bit,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             en_bit,
    input  logic             clr_strobe,
    input  logic             test_strobe,
    output logic             irq_mtimer,
    output logic             irq_periph,
    output logic             status_bit
);
    logic hit;

    // Unsigned 64-bit compare, gated by the run bit.
    assign hit        = run_bit && (cmp_val <= cnt_val);
    assign irq_mtimer = hit;
    assign irq_periph = status_bit && en_bit;

    // Sticky status: a set has priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                          status_bit <= 1'b0;
        else if (en_bit && (hit || test_strobe)) status_bit <= 1'b1;
        else if (clr_strobe)                 status_bit <= 1'b0;
    end
endmodule

// File: rtl/mtimer_core.sv
// Top of the compare timer: a register bus front end, the tick counter
// and the compare/interrupt logic. Assumes a single clock and a
// synchronous active-low reset.
module mtimer_core
    import mtmr_pkg::*;
#(
    parameter int PRESCALE_W = 12,
    parameter int STEP_W     = 8,
    parameter int STEP_LSB   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              irq_mtimer,
    output logic              irq_periph
);
    localparam int CNT_W = 2 * DATA_W;

    logic                  run_bit;
    logic [PRESCALE_W-1:0] prescale;
    logic [STEP_W-1:0]     step;
    logic [CNT_W-1:0]      cmp_val;
    logic [CNT_W-1:0]      cnt_val;
    logic [PRESCALE_W-1:0] pre_val;
    logic                  en_bit;
    logic                  status_bit;
    logic                  clr_strobe;
    logic                  test_strobe;

    mtmr_regs #(
        .PRESCALE_W(PRESCALE_W), .STEP_W(STEP_W), .STEP_LSB(STEP_LSB)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .cnt_val(cnt_val), .status_bit(status_bit),
        .rsp_rdata(rsp_rdata), .run_bit(run_bit),
        .prescale(prescale), .step(step), .cmp_val(cmp_val),
        .en_bit(en_bit), .clr_strobe(clr_strobe), .test_strobe(test_strobe)
    );

    mtmr_tick #(
        .PRESCALE_W(PRESCALE_W), .STEP_W(STEP_W), .CNT_W(CNT_W)
    ) u_tick (
        .clk(clk), .rst_n(rst_n), .run_bit(run_bit),
        .prescale(prescale), .step(step),
        .cnt_val(cnt_val), .pre_val(pre_val)
    );

    mtmr_irq #(.CNT_W(CNT_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .run_bit(run_bit),
        .cmp_val(cmp_val), .cnt_val(cnt_val), .en_bit(en_bit),
        .clr_strobe(clr_strobe), .test_strobe(test_strobe),
        .irq_mtimer(irq_mtimer), .irq_periph(irq_periph),
        .status_bit(status_bit)
    );
endmodule

// File: rtl/mtmr_checks.sv
// Assertion checker for mtimer_core, attached with bind below.
module mtmr_checks
    import mtmr_pkg::*;
#(
    parameter int PRESCALE_W = 12,
    parameter int STEP_W     = 8,
    parameter int CNT_W      = 64
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic                  req_write,
    input logic [ADDR_W-1:0]     req_addr,
    input logic [DATA_W-1:0]     req_wdata,
    input logic [DATA_W-1:0]     rsp_rdata,
    input logic                  irq_mtimer,
    input logic                  irq_periph,
    input logic                  run_bit,
    input logic [PRESCALE_W-1:0] prescale,
    input logic [STEP_W-1:0]     step,
    input logic [PRESCALE_W-1:0] pre_val,
    input logic [CNT_W-1:0]      cnt_val,
    input logic                  en_bit,
    input logic                  status_bit
);
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !run_bit |=> $stable(cnt_val)); // R3
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_bit && pre_val == prescale) |=>
        cnt_val == $past(cnt_val) + {{(CNT_W-STEP_W){1'b0}}, $past(step)}); // R3
    AST_RAW_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !run_bit |-> !irq_mtimer); // R5
    AST_PERIPH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_periph |-> (en_bit && status_bit)); // R6
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == OFS_STATUS && req_wdata[0] && !irq_mtimer)
        |=> !status_bit); // R7
    AST_TEST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == OFS_TEST && !en_bit && !status_bit)
        |=> !status_bit); // R8
    AST_ALERT_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == OFS_ALERT) |=> rsp_rdata == '0); // R9
endmodule

bind mtimer_core mtmr_checks #(
    .PRESCALE_W(PRESCALE_W), .STEP_W(STEP_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .irq_mtimer(irq_mtimer), .irq_periph(irq_periph), .run_bit(run_bit),
    .prescale(prescale), .step(step), .pre_val(pre_val), .cnt_val(cnt_val),
    .en_bit(en_bit), .status_bit(status_bit)
);

// File: tb/mtimer_core_test.sv
module mtimer_core_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [9:0]  req_addr;
    logic [31:0] req_wdata;
    logic [31:0] rsp_rdata;
    logic        irq_mtimer, irq_periph;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mtimer_core uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .irq_mtimer(irq_mtimer), .irq_periph(irq_periph)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rsp_rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
        @(negedge clk);
        do_reset();

        // R1 reset values
        check("R1 irq_mtimer", irq_mtimer, 0);
        check("R1 irq_periph", irq_periph, 0);
        rd(10'h004, d); check("R1 run", d, 0);
        rd(10'h100, d); check("R1 cfg", d, 32'h0001_0000);
        rd(10'h10C, d); check("R1 cmp lo", d, 32'hFFFF_FFFF);
        rd(10'h110, d); check("R1 cmp hi", d, 32'hFFFF_FFFF);
        rd(10'h114, d); check("R1 enable", d, 0);
        rd(10'h118, d); check("R1 status", d, 0);
        rd(10'h104, d); check("R1 cnt lo", d, 0);
        rd(10'h108, d); check("R1 cnt hi", d, 0);

        // R3 sweep of prescale, step and running edge count
        for (int p = 0; p < 4; p++) begin
            for (int si = 0; si < 4; si++) begin
                for (int w = 6; w <= 12; w += 6) begin
                    int s;
                    longint k;
                    s = (si == 0) ? 1 : (si == 1) ? 2 : (si == 2) ? 5 : 255;
                    do_reset();
                    wr(10'h100, (32'(s) << 16) | 32'(p));
                    wr(10'h004, 1);
                    repeat (w) @(negedge clk);
                    wr(10'h004, 0);
                    k = longint'(w + 1);
                    rd(10'h104, d);
                    check($sformatf("R3 count p=%0d s=%0d k=%0d", p, s, k),
                          d, 64'((k / (p + 1)) * s));
                end
            end
        end

        // Freeze the counter at 10 while running
        do_reset();
        wr(10'h100, 32'h0001_0000);
        wr(10'h004, 1);
        repeat (9) @(negedge clk);
        wr(10'h004, 0);
        wr(10'h100, 32'h0001_0FFF);
        rd(10'h104, d); check("R3 count ten", d, 10);
        repeat (5) @(negedge clk);
        rd(10'h104, d); check("R3 hold while stopped", d, 10);
        wr(10'h104, 32'h55); wr(10'h108, 32'h7);
        rd(10'h104, d); check("R4 cnt lo write ignored", d, 10);
        rd(10'h108, d); check("R4 cnt hi write ignored", d, 0);

        wr(10'h110, 0);
        wr(10'h004, 1);
        check("R5 cmp above count", irq_mtimer, 0);
        for (int v = 7; v <= 13; v++) begin
            wr(10'h10C, 32'(v));
            check($sformatf("R5 raw cmp=%0d", v), irq_mtimer, (v <= 10) ? 1 : 0);
            check($sformatf("R6 periph off cmp=%0d", v), irq_periph, 0);
        end
        wr(10'h10C, 5);
        wr(10'h110, 1);
        check("R5 high word compared", irq_mtimer, 0);
        wr(10'h110, 0);
        check("R5 raw ignores enable", irq_mtimer, 1);
        rd(10'h118, d); check("R6 status stays clear when disabled", d, 0);

        wr(10'h114, 1);
        @(negedge clk);
        check("R6 periph raised", irq_periph, 1);
        rd(10'h118, d); check("R6 status set", d, 1);
        wr(10'h114, 0);
        check("R6 periph masked", irq_periph, 0);
        rd(10'h118, d); check("R6 status sticky", d, 1);

        wr(10'h10C, 20);
        check("R5 no hit after cmp raise", irq_mtimer, 0);
        wr(10'h118, 0);
        rd(10'h118, d); check("R7 zero write keeps status", d, 1);
        wr(10'h118, 1);
        rd(10'h118, d); check("R7 one write clears status", d, 0);

        wr(10'h11C, 1);
        rd(10'h118, d); check("R8 test ignored when disabled", d, 0);
        wr(10'h114, 1);
        wr(10'h11C, 0);
        rd(10'h118, d); check("R8 test bit0 zero no effect", d, 0);
        check("R8 periph low before test", irq_periph, 0);
        wr(10'h11C, 1);
        rd(10'h118, d); check("R8 test sets status", d, 1);
        check("R8 test raises periph", irq_periph, 1);

        wr(10'h10C, 5);
        check("R5 hit while running", irq_mtimer, 1);
        wr(10'h004, 0);
        check("R5 raw low when stopped", irq_mtimer, 0);

        wr(10'h000, 32'hFFFF_FFFF);
        check("R9 alert write leaves periph", irq_periph, 1);
        rd(10'h118, d); check("R9 alert write leaves status", d, 1);
        rd(10'h000, d); check("R9 alert reads zero", d, 0);
        rd(10'h11C, d); check("R9 test reads zero", d, 0);
        rd(10'h200, d); check("R9 unmapped reads zero", d, 0);
        rd(10'h3FC, d); check("R9 top of window reads zero", d, 0);

        rd(10'h100, d); check("R2 cfg readback", d, 32'h0001_0FFF);
        rd(10'h10C, d); check("R2 cmp lo readback", d, 5);
        rd(10'h110, d); check("R2 cmp hi readback", d, 0);
        rd(10'h114, d); check("R2 enable readback", d, 1);
        rd(10'h004, d); check("R2 run readback", d, 0);
        wr(10'h100, 32'h00AB_0123);
        rd(10'h100, d); check("R2 cfg fields readback", d, 32'h00AB_0123);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule